// File: doc/BRIEF.md
# Buffered-Update Pulse-Width Modulation Channel

This block produces one pulse-width modulated output. A 16-bit period counter advances once per prescaled tick, where the tick rate is the core clock divided by a power of two chosen by a 4-bit field. The output is in its active level while the count is below the duty value, and a polarity input chooses whether the active level is high or low.

While the channel is stopped, duty and period writes land in the working registers at once. While it runs, writes are parked in per-value shadow registers and only reach the working registers at the end of the period in progress, so a period is never cut short or stretched by a write. The channel flags each period end with a one-cycle pulse, keeps a running flag high while it is active, and on a stop request finishes the period in progress before it goes idle, so the flag can be polled to see when the stop has taken effect.

Top module: `pwm_chan_top`

## Requirements
- R1: After reset, `running` and `period_end` are 0 and `pwm_out` equals `invert` (inactive level); duty and period reset to 0.
- R2: Once started with prescale N (0..10) and period P, the counter steps 0,1,...,P-1,0,... advancing one step every 2^N clocks; with `invert`=0 `pwm_out` is 1 while count < duty and 0 otherwise.
- R3: With `invert`=1 the output levels of R2 are swapped (active level is 0), and while idle `pwm_out` stays 1.
- R4: A prescale value from 11 to 15 divides the clock by 2^10, the same as 10.
- R5: Duty 0 gives a constant inactive output; duty greater than or equal to the period gives a constant active output; a period of 0 behaves as a period of 1.
- R6: A duty or period write (`wr_duty`/`wr_period` with `wr_data`) while idle takes effect immediately, so the next start uses it from its first cycle.
- R7: A duty or period write while running does not change the period in progress; the value is applied at the next period end, and a later write before that boundary replaces an earlier one.
- R8: `period_end` is high for the single clock in which the counter sits at its last value and a tick occurs; the next clock begins a new period at count 0.
- R9: After `dis_req` while running, `running` stays 1 until the cycle after the next `period_end` (or the cycle after the request if it coincides with a `period_end`), then falls and `pwm_out` returns to the inactive level.
- R10: `en_req` while idle restarts the counter and prescaler at 0 and raises `running` on the next clock; `en_req` while running and `dis_req` while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Start request pulse |
| dis_req | input | 1 | Stop request pulse |
| wr_duty | input | 1 | Duty write strobe |
| wr_period | input | 1 | Period write strobe |
| wr_data | input | 16 | Value for duty or period write |
| prescale | input | 4 | Tick divider exponent N, clock divided by 2^min(N,10) |
| invert | input | 1 | 1 makes the active level low |
| pwm_out | output | 1 | Modulated output |
| period_end | output | 1 | One-cycle pulse at each period boundary |
| running | output | 1 | High while the channel is active or finishing its last period |

## Verification
The assertions watch every cycle for the properties that hold independently of stimulus: the working duty never moves mid-period while running, the running flag only falls right after a period boundary, the idle output sits at the inactive level, duty extremes pin the output, and the count stays within the period. What only the bench scenarios can show is the exact waveform timing under each prescale and period, the clamp of large prescale values, the moment a buffered write becomes visible, and that repeated start or stray stop requests leave the waveform untouched.

// File: rtl/pwm_pkg.sv
// Package: shared types for the PWM channel.
// Assumes nothing beyond a single clock domain.
package pwm_pkg;
    // Channel control states: stopped, running, finishing the last period.
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_STOP = 2'd2
    } ch_state_t;

    localparam int VAL_W_DEF   = 16;
    localparam int SEL_W_DEF   = 4;
    localparam int MAX_LOG_DEF = 10;
endpackage

// File: rtl/pwm_tick_gen.sv
// Module: prescaled tick generator.
// A free-running phase counter, cleared on start, emits a one-cycle tick
// whenever its low sel bits are all ones, i.e. once every 2^sel clocks.
// Selector values above MAX_LOG behave as MAX_LOG because the phase
// counter has only MAX_LOG bits.
module pwm_tick_gen #(
    parameter int SEL_W   = 4,
    parameter int MAX_LOG = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PH_W = (MAX_LOG > 0) ? MAX_LOG : 1;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] mask;

    // Per-bit mask: bit i takes part in the compare when sel exceeds i.
    for (genvar i = 0; i < PH_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    // Phase counter: cleared on start, advances only while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Tick when every selected low bit of the phase is set.
    assign tick = run && ((phase_q & mask) == mask);
endmodule

// File: rtl/pwm_shadow_reg.sv
// Module: working value with a shadow buffer.
// While idle a write loads the working value directly. While running a
// write goes to the buffer and the working value takes it at the next
// boundary. A write in the same cycle as a boundary becomes the new
// pending value after the older one is applied.
module pwm_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         idle,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         boundary,
    output logic [W-1:0] value
);
    logic [W-1:0] act_q;
    logic [W-1:0] buf_q;
    logic         pend_q;

    // Working value, buffer and pending flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            buf_q  <= '0;
            pend_q <= 1'b0;
        end else if (wr && idle) begin
            act_q  <= wr_data;
            pend_q <= 1'b0;
        end else begin
            if (boundary && pend_q) begin
                act_q <= buf_q;
            end
            if (wr) begin
                buf_q  <= wr_data;
                pend_q <= 1'b1;
            end else if (boundary) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign value = act_q;
endmodule

// File: rtl/pwm_period_cnt.sv
// Module: period counter and duty compare.
// Counts 0..period-1 on ticks and wraps; a period of 0 wraps every tick.
// Assumes the caller clears it on start and only changes the period at
// a wrap, so the count never exceeds period-1.
module pwm_period_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] period,
    input  logic [W-1:0] duty,
    output logic [W-1:0] count,
    output logic         last,
    output logic         active
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] per_m1;

    // Last count value of the period, with period 0 treated as 1.
    always_comb begin
        per_m1 = (period == '0) ? '0 : period - 1'b1;
    end

    assign last = (cnt_q >= per_m1);

    // Counter: cleared on start, steps or wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    assign active = (cnt_q < duty);
    assign count  = cnt_q;
endmodule

// File: rtl/pwm_chan_top.sv
// Module: single PWM channel with buffered duty/period update.
// Holds the start/stop state machine and wires the tick generator, the
// two shadowed values and the period counter. A stop request completes
// the period in progress; the running flag stays high until then.
module pwm_chan_top #(
    parameter int VAL_W   = pwm_pkg::VAL_W_DEF,
    parameter int SEL_W   = pwm_pkg::SEL_W_DEF,
    parameter int MAX_LOG = pwm_pkg::MAX_LOG_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             dis_req,
    input  logic             wr_duty,
    input  logic             wr_period,
    input  logic [VAL_W-1:0] wr_data,
    input  logic [SEL_W-1:0] prescale,
    input  logic             invert,
    output logic             pwm_out,
    output logic             period_end,
    output logic             running
);
    import pwm_pkg::*;

    localparam int NUM_VALS = 2;
    localparam int IDX_DUTY = 0;
    localparam int IDX_PER  = 1;

    ch_state_t        st_q, st_d;
    logic             start;
    logic             tick;
    logic             last;
    logic             active;
    logic             boundary;
    logic             idle;
    logic [VAL_W-1:0] cnt_q;
    logic [VAL_W-1:0] duty_act;
    logic [VAL_W-1:0] per_act;
    logic [NUM_VALS-1:0] wr_vec;
    logic [VAL_W-1:0] val_vec [NUM_VALS];

    assign idle     = (st_q == CH_IDLE);
    assign running  = !idle;
    assign start    = idle && en_req;
    assign boundary = tick && last;

    // Next-state logic for start, stop request and stop completion.
    always_comb begin
        st_d = st_q;
        case (st_q)
            CH_IDLE: if (en_req) st_d = CH_RUN;
            CH_RUN: begin
                if (dis_req) st_d = boundary ? CH_IDLE : CH_STOP;
            end
            CH_STOP: if (boundary) st_d = CH_IDLE;
            default: st_d = CH_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    pwm_tick_gen #(
        .SEL_W   (SEL_W),
        .MAX_LOG (MAX_LOG)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .run   (running),
        .sel   (prescale),
        .tick  (tick)
    );

    assign wr_vec[IDX_DUTY] = wr_duty;
    assign wr_vec[IDX_PER]  = wr_period;

    // One shadowed register per programmable value.
    for (genvar g = 0; g < NUM_VALS; g++) begin : g_val
        pwm_shadow_reg #(.W(VAL_W)) u_shadow (
            .clk      (clk),
            .rst_n    (rst_n),
            .idle     (idle),
            .wr       (wr_vec[g]),
            .wr_data  (wr_data),
            .boundary (boundary),
            .value    (val_vec[g])
        );
    end

    assign duty_act = val_vec[IDX_DUTY];
    assign per_act  = val_vec[IDX_PER];

    pwm_period_cnt #(.W(VAL_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .tick   (tick),
        .period (per_act),
        .duty   (duty_act),
        .count  (cnt_q),
        .last   (last),
        .active (active)
    );

    assign pwm_out    = (running && active) ^ invert;
    assign period_end = boundary;
endmodule

// File: rtl/pwm_chan_checker.sv
// Module: property checker for pwm_chan_top, attached by bind.
module pwm_chan_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         running,
    input logic         period_end,
    input logic         pwm_out,
    input logic         invert,
    input logic [W-1:0] duty_act,
    input logic [W-1:0] per_act,
    input logic [W-1:0] cnt
);
    // R9: running may only fall right after a period end.
    p_stop_on_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(period_end));

    // R1: idle output sits at the inactive level.
    p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pwm_out == invert));

    // R5: zero duty pins the output inactive.
    p_duty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && duty_act == '0) |-> (pwm_out == invert));

    // R5: duty at or above the period pins the output active.
    p_duty_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && per_act != '0 && duty_act >= per_act) |-> (pwm_out == !invert));

    // R7: working duty and period hold except at a period end.
    p_duty_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !period_end) |=> ($stable(duty_act) && $stable(per_act)));

    // R10: a start begins at count 0.
    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (cnt == '0));

    // R2: count stays below the period.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && per_act != '0) |-> (cnt < per_act));

    // R8: period end only occurs while running.
    p_pe_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> running);
endmodule

bind pwm_chan_top pwm_chan_checker #(.W(VAL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .period_end (period_end),
    .pwm_out    (pwm_out),
    .invert     (invert),
    .duty_act   (duty_act),
    .per_act    (per_act),
    .cnt        (cnt_q)
);

// File: tb/sim_pwm_chan_top.sv
module sim_pwm_chan_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_req, dis_req, wr_duty, wr_period, invert;
    logic [15:0] wr_data;
    logic [3:0]  prescale;
    logic        pwm_out, period_end, running;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [3:0]  pre;
        logic [15:0] per;
        logic [15:0] duty;
        logic        inv;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 16'd4, 16'd2, 1'b0},
        '{4'd1, 16'd5, 16'd3, 1'b1},
        '{4'd2, 16'd3, 16'd0, 1'b0},
        '{4'd0, 16'd3, 16'd5, 1'b1},
        '{4'd3, 16'd2, 16'd1, 1'b0},
        '{4'd0, 16'd0, 16'd1, 1'b0},
        '{4'd1, 16'd6, 16'd6, 1'b1},
        '{4'd0, 16'd7, 16'd1, 1'b1}
    };

    always #5 clk = ~clk;

    pwm_chan_top u0 (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .wr_duty(wr_duty), .wr_period(wr_period), .wr_data(wr_data),
        .prescale(prescale), .invert(invert),
        .pwm_out(pwm_out), .period_end(period_end), .running(running)
    );

    task automatic check(input bit ok, input string tag,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_val(input bit is_per, input logic [15:0] v);
        wr_data = v;
        if (is_per) wr_period = 1'b1; else wr_duty = 1'b1;
        step();
        wr_period = 1'b0;
        wr_duty   = 1'b0;
    endtask

    task automatic start();
        en_req = 1'b1;
        step();
        en_req = 1'b0;
    endtask

    task automatic stop_and_wait(input logic inv);
        dis_req = 1'b1;
        step();
        dis_req = 1'b0;
        for (int i = 0; i < 40000 && running; i++) step();
        check(running == 1'b0, "R9 stopped", running, 0);
        check(pwm_out == inv, "R9 idle level", pwm_out, inv);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en_req = 0; dis_req = 0; wr_duty = 0; wr_period = 0;
        wr_data = '0; prescale = '0; invert = 1'b0;
        step(); step();
        // R1: reset state
        check(running == 0, "R1 running", running, 0);
        check(period_end == 0, "R1 period_end", period_end, 0);
        check(pwm_out == 0, "R1 pwm_out", pwm_out, 0);
        rst_n = 1'b1;
        step();
        invert = 1'b1;
        #1;
        check(pwm_out == 1, "R3 idle inverted", pwm_out, 1);
        invert = 1'b0;

        // Table walk: R6 idle programming, then R2/R3/R5/R8 waveform.
        for (int v = 0; v < NV; v++) begin
            int n, pe, mask, ncyc;
            prescale = VECS[v].pre;
            invert   = VECS[v].inv;
            wr_val(1'b1, VECS[v].per);
            wr_val(1'b0, VECS[v].duty);
            n    = (VECS[v].pre > 10) ? 10 : int'(VECS[v].pre);
            pe   = (VECS[v].per == 0) ? 1 : int'(VECS[v].per);
            mask = (1 << n) - 1;
            ncyc = 3 * pe * (1 << n);
            start();
            check(running == 1, "R10 started", running, 1);
            for (int k = 0; k < ncyc; k++) begin
                int cn;
                logic eo, ep;
                string tg;
                cn = (k >> n) % pe;
                eo = (cn < int'(VECS[v].duty)) ^ VECS[v].inv;
                ep = ((k & mask) == mask) && (cn == pe - 1);
                if (VECS[v].duty == 0 || int'(VECS[v].duty) >= pe) tg = "R5 level";
                else if (k == 0) tg = "R6 first cycle";
                else if (VECS[v].inv) tg = "R3 level";
                else tg = "R2 level";
                check(pwm_out == eo, tg, pwm_out, eo);
                check(period_end == ep, "R8 period_end", period_end, ep);
                step();
            end
            stop_and_wait(VECS[v].inv);
        end

        // R7: buffered writes while running.
        prescale = 4'd0; invert = 1'b0;
        wr_val(1'b1, 16'd4);
        wr_val(1'b0, 16'd1);
        start();                        // k=0
        step();                         // k=1
        wr_data = 16'd2; wr_duty = 1'b1;
        step();                         // k=2, buffered 2
        wr_data = 16'd3;
        step();                         // k=3, replaced by 3
        wr_duty = 1'b0;
        check(pwm_out == 0, "R7 old duty held", pwm_out, 0);
        check(period_end == 1, "R7 old boundary", period_end, 1);
        step();                         // k=4 cnt0
        step();                         // k=5 cnt1
        check(pwm_out == 1, "R7 new duty applied", pwm_out, 1);
        step();                         // k=6 cnt2
        check(pwm_out == 1, "R7 later write wins", pwm_out, 1);
        wr_val(1'b1, 16'd6);            // captured at k=6->7
        check(period_end == 1, "R7 old period kept", period_end, 1);
        for (int i = 0; i < 4; i++) step();  // k=11 cnt3
        check(period_end == 0, "R7 new period", period_end, 0);
        step(); step();                 // k=13 cnt5
        check(period_end == 1, "R7 new period end", period_end, 1);
        step();                         // k=14 cnt0
        // R9: stop completes the period.
        dis_req = 1'b1;
        step();                         // k=15 cnt1
        dis_req = 1'b0;
        check(running == 1, "R9 still running", running, 1);
        for (int i = 0; i < 4; i++) step(); // k=19 cnt5
        check(running == 1 && period_end == 1, "R9 last period end",
              {running, period_end}, 3);
        step();
        check(running == 0, "R9 fell after boundary", running, 0);
        check(pwm_out == 0, "R9 inactive after stop", pwm_out, 0);

        // R9: stop request on a boundary ends at once.
        wr_val(1'b1, 16'd3);
        start(); step(); step();        // k=2 boundary
        dis_req = 1'b1;
        step();
        dis_req = 1'b0;
        check(running == 0, "R9 stop on boundary", running, 0);

        // R10: start while running and stop while idle are ignored.
        dis_req = 1'b1; step(); dis_req = 1'b0;
        check(running == 0, "R10 idle stop ignored", running, 0);
        wr_val(1'b1, 16'd4);
        wr_val(1'b0, 16'd2);
        start(); step();                // k=1
        en_req = 1'b1; step(); en_req = 1'b0;  // k=2
        check(pwm_out == 0, "R10 restart ignored", pwm_out, 0);
        step();                         // k=3
        check(period_end == 1, "R10 phase kept", period_end, 1);
        stop_and_wait(1'b0);

        // R4: prescale 15 divides by 1024.
        prescale = 4'd15;
        wr_val(1'b1, 16'd2);
        wr_val(1'b0, 16'd1);
        start();
        for (int i = 0; i < 1023; i++) step();  // k=1023
        check(pwm_out == 1, "R4 before tick", pwm_out, 1);
        check(period_end == 0, "R4 no early end", period_end, 0);
        step();                         // k=1024
        check(pwm_out == 0, "R4 after tick", pwm_out, 0);
        for (int i = 0; i < 1023; i++) step();  // k=2047
        check(period_end == 1, "R4 period end", period_end, 1);
        step();

        // R1: reset while running.
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check(running == 0, "R1 reset mid-run", running, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule